// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is a single programmable interval timer channel for a larger peripheral cluster. Software reaches three 16-bit registers through a simple register port. A control word picks the prescale exponent, which of two compare-maximum registers sets the terminal count, repeat or one-shot behaviour, interrupt enable and a stop bit. Two limit registers hold the candidate maximum values.

Once a control write starts it, the timer counts system clocks through a power-of-two prescaler. When the elapsed clock count reaches 2^P × limit, it can emit a one-cycle interrupt request toward an interrupt controller. It then either begins a new period or goes idle until software writes the control register again. The settings a period uses are captured when the control register is written. Later limit-register writes wait for the next control write.

Top module: `tmr_interval`

## Requirements
- R1: After reset the interrupt output is low and all three registers read back as 0x0000.
- R2: The register port decodes 3-bit byte offsets: control at 0, first limit at 4, second limit at 6. Each reads back the full 16 bits written. Every other offset reads 0x0000, and a write to it changes no register.
- R3: Control bits 13:10 hold the exponent P and bits 5:4 choose the limit (01 first limit, 10 second limit). The interrupt is a one-cycle pulse, first high in the cycle that ends 2^P × limit clock edges after the edge that took the control write.
- R4: A P value above 8 gives the same period as P = 8.
- R5: With control bit 7 set the pulse repeats every 2^P × limit cycles. With bit 7 clear exactly one pulse occurs, then the timer stays idle.
- R6: With control bit 2 (interrupt enable) clear, no pulse is produced.
- R7: The timer does not run, and produces no pulse, if control bit 1 (stop) is set, if bits 5:4 are 00 or 11, if the selected limit is zero, or if bits 15:14 (clock source) are not 00.
- R8: Every control write restarts the count from zero with the newly written settings, and it cancels any expiry on that same edge.
- R9: A limit-register write does not change the period in progress. The new value applies from the next control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the count source |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Byte offset of the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Byte offset of the combinational read |
| rd_data | output | 16 | Read data |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
The bench builds the block with its defaults: a prescale ceiling of 8 and 16-bit limits. At these values, periods of 3 to 256 clocks reach every prescale step, including the clamp at 256 for an oversize exponent. Small limits allow several repeat periods within a short run. They also allow a restart in mid-period and a limit change during a running period, both checked against exact pulse cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 3;
    localparam int PEXP_W  = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_LIM1 = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_LIM2 = 3'd6;

    typedef enum logic [1:0] {
        LSEL_NONE = 2'b00,
        LSEL_ONE  = 2'b01,
        LSEL_TWO  = 2'b10,
        LSEL_BAD  = 2'b11
    } lim_sel_e;

    // Control word layout; the field positions are the software contract.
    typedef struct packed {
        logic [1:0]        src;      // 15:14, 00 = system clock
        logic [PEXP_W-1:0] pexp;     // 13:10
        logic [1:0]        rsv_a;    // 9:8
        logic              rpt;      // 7
        logic              rsv_b;    // 6
        lim_sel_e          lsel;     // 5:4
        logic              rsv_c;    // 3
        logic              ien;      // 2
        logic              halt;     // 1
        logic              rsv_d;    // 0
    } ctrl_t;

    // Settings captured when a period is started.
    typedef struct packed {
        logic              run;
        logic              rpt;
        logic              ien;
        logic [PEXP_W-1:0] pexp;
        logic [DATA_W-1:0] limit;
    } cfg_t;

    function automatic logic [PEXP_W-1:0] clamp_exp(input logic [PEXP_W-1:0] p,
                                                    input int ceiling);
        return (int'(p) > ceiling) ? PEXP_W'(ceiling) : p;
    endfunction

    function automatic cfg_t decode_cfg(input ctrl_t c,
                                        input logic [DATA_W-1:0] lim1,
                                        input logic [DATA_W-1:0] lim2,
                                        input int ceiling);
        cfg_t r;
        r.rpt  = c.rpt;
        r.ien  = c.ien;
        r.pexp = clamp_exp(c.pexp, ceiling);
        case (c.lsel)
            LSEL_ONE: r.limit = lim1;
            LSEL_TWO: r.limit = lim2;
            default:  r.limit = '0;
        endcase
        r.run = (c.src == 2'b00) && !c.halt && (r.limit != '0);
        return r;
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] lim1_q,
    output logic [DATA_W-1:0] lim2_q,
    output logic              ctrl_wr
);

    logic hit_lim1, hit_lim2, mapped;

    always_comb begin
        ctrl_wr  = wr_en && (wr_addr == OFS_CTRL);
        hit_lim1 = wr_en && (wr_addr == OFS_LIM1);
        hit_lim2 = wr_en && (wr_addr == OFS_LIM2);
        mapped   = (wr_addr == OFS_CTRL) || (wr_addr == OFS_LIM1) ||
                   (wr_addr == OFS_LIM2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            lim1_q <= '0;
            lim2_q <= '0;
        end else begin
            if (ctrl_wr)  ctrl_q <= ctrl_t'(wr_data);
            if (hit_lim1) lim1_q <= wr_data;
            if (hit_lim2) lim2_q <= wr_data;
        end
    end

    always_comb begin
        case (rd_addr)
            OFS_CTRL: rd_data = DATA_W'(ctrl_q);
            OFS_LIM1: rd_data = lim1_q;
            OFS_LIM2: rd_data = lim2_q;
            default:  rd_data = '0;
        endcase
    end

    // R2: a write outside the map leaves every register untouched
    a_r2_unmapped_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mapped) |=> ($stable(ctrl_q) && $stable(lim1_q) && $stable(lim2_q)));

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int P_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              run,
    input  logic [PEXP_W-1:0] pexp,
    output logic              tick
);

    localparam int PRE_W = (P_LIMIT < 1) ? 1 : P_LIMIT;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] wrap;

    always_comb begin
        wrap = ~({PRE_W{1'b1}} << pexp);
        tick = run && (pre_q == wrap);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) pre_q <= '0;
        else if (run)       pre_q <= tick ? '0 : pre_q + PRE_W'(1);
    end

    // R4: the exponent handed in is never above the ceiling
    a_r4_exp_clamped: assert property (@(posedge clk) disable iff (rst)
        int'(pexp) <= P_LIMIT);

    // R3: the prescale count never passes its wrap point
    a_r3_pre_in_range: assert property (@(posedge clk) disable iff (rst)
        (run && !restart) |-> (pre_q <= wrap));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             start_run,
    input  logic             rpt,
    input  logic [CNT_W-1:0] limit,
    input  logic             tick,
    output logic             run,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    always_comb expire = run && tick && (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            cnt_q <= '0;
        end else if (restart) begin
            run   <= start_run;
            cnt_q <= '0;
        end else if (expire) begin
            run   <= rpt;
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R5: a one-shot expiry leaves the timer idle
    a_r5_oneshot_halts: assert property (@(posedge clk) disable iff (rst)
        (expire && !rpt && !restart) |=> !run);

    // R5: a repeat expiry keeps the timer running
    a_r5_repeat_continues: assert property (@(posedge clk) disable iff (rst)
        (expire && rpt && !restart) |=> run);

endmodule

// File: rtl/tmr_interval.sv
module tmr_interval
    import tmr_pkg::*;
#(
    parameter int P_LIMIT = 8,
    parameter int CNT_W   = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] lim1_q, lim2_q;
    logic              ctrl_wr;
    cfg_t              cfg_next, cfg_q;
    logic              tick, run, expire;

    tmr_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ctrl_q  (ctrl_q),
        .lim1_q  (lim1_q),
        .lim2_q  (lim2_q),
        .ctrl_wr (ctrl_wr)
    );

    always_comb cfg_next = decode_cfg(ctrl_t'(wr_data), lim1_q, lim2_q, P_LIMIT);

    always_ff @(posedge clk) begin
        if (rst)          cfg_q <= '0;
        else if (ctrl_wr) cfg_q <= cfg_next;
    end

    tmr_prescaler #(.P_LIMIT(P_LIMIT)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (ctrl_wr),
        .run     (run),
        .pexp    (cfg_q.pexp),
        .tick    (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .restart   (ctrl_wr),
        .start_run (cfg_next.run),
        .rpt       (cfg_q.rpt),
        .limit     (CNT_W'(cfg_q.limit)),
        .tick      (tick),
        .run       (run),
        .expire    (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= expire && cfg_q.ien && !ctrl_wr;
    end

    // R6: a pulse only appears while the stored control word enables it
    a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> ctrl_q.ien);

    // R8: a control write cancels any pulse on the following cycle
    a_r8_write_restarts: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> !irq);

    // R7: a pulse needs the timer to have been running
    a_r7_irq_from_running: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(run));

endmodule

// File: tb/test_tmr_interval.sv
`timescale 1ns/1ps
module test_tmr_interval;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        irq;

    tmr_interval i_tmr_interval (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #5 clk = ~clk;

    int    cyc = 0;
    int    vectors = 0;
    int    errors = 0;
    string cur_req = "R1";
    int    expq[$];

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: every observed pulse must match the next expected cycle
    always @(negedge clk) begin
        if (!rst && irq) begin
            vectors++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected pulse at cycle %0d, expected none", cur_req, cyc);
            end else begin
                int e;
                e = expq.pop_front();
                if (e != cyc) begin
                    errors++;
                    $display("FAIL %s: pulse at cycle %0d, expected %0d", cur_req, cyc, e);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d, output int wc);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wc = cyc;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic drained(input string req);
        @(negedge clk);
        vectors++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d pulses missing, expected 0", req, expq.size());
            expq.delete();
        end
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [15:0] exp_v, input string req);
        @(negedge clk);
        rd_addr = a; #1;
        vectors++;
        if (rd_data !== exp_v) begin
            errors++;
            $display("FAIL %s: read offset %0d got %h, expected %h", req, a, rd_data, exp_v);
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int w, w2;
        idle(3);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        cur_req = "R1";
        @(negedge clk);
        vectors++;
        if (irq !== 1'b0) begin errors++; $display("FAIL R1: irq %b, expected 0", irq); end
        rd_check(3'd0, 16'h0000, "R1");
        rd_check(3'd4, 16'h0000, "R1");
        rd_check(3'd6, 16'h0000, "R1");

        // R2 register port and unmapped offsets
        cur_req = "R2";
        wr(3'd4, 16'h1234, w);
        wr(3'd6, 16'hBEEF, w);
        wr(3'd2, 16'hFFFF, w);
        wr(3'd7, 16'hAAAA, w);
        rd_check(3'd4, 16'h1234, "R2");
        rd_check(3'd6, 16'hBEEF, "R2");
        rd_check(3'd2, 16'h0000, "R2");
        rd_check(3'd0, 16'h0000, "R2");
        wr(3'd0, 16'h0002, w);
        rd_check(3'd0, 16'h0002, "R2");

        // R3 + R5 repeat, P=0, first limit 3: pulses every 3 cycles
        cur_req = "R5";
        wr(3'd4, 16'd3, w);
        wr(3'd0, 16'h0094, w);
        for (int k = 1; k <= 4; k++) expq.push_back(w + 3*k);
        idle(13);
        wr(3'd0, 16'h0002, w2);
        drained("R5");

        // R3 + R5 one-shot, P=2, second limit 5: one pulse after 20
        cur_req = "R3";
        wr(3'd6, 16'd5, w);
        wr(3'd0, 16'h0824, w);
        expq.push_back(w + 20);
        idle(70);
        drained("R3");

        // R4 exponent 12 clamps to 8: period 256 with limit 1
        cur_req = "R4";
        wr(3'd4, 16'd1, w);
        wr(3'd0, 16'h3014, w);
        expq.push_back(w + 256);
        idle(300);
        drained("R4");

        // R6 interrupt disabled, repeat running
        cur_req = "R6";
        wr(3'd4, 16'd3, w);
        wr(3'd0, 16'h0090, w);
        idle(30);
        drained("R6");

        // R7 cases that must not run
        cur_req = "R7";
        wr(3'd0, 16'h0096, w); idle(20); drained("R7");
        wr(3'd0, 16'h0084, w); idle(20); drained("R7");
        wr(3'd0, 16'h00B4, w); idle(20); drained("R7");
        wr(3'd0, 16'h4094, w); idle(20); drained("R7");
        wr(3'd4, 16'd0, w);
        wr(3'd0, 16'h0094, w); idle(20); drained("R7");

        // R8 restart mid-period with new settings
        cur_req = "R8";
        wr(3'd4, 16'd3, w);
        wr(3'd0, 16'h0894, w);
        idle(8);
        wr(3'd0, 16'h0094, w2);
        expq.push_back(w2 + 3);
        expq.push_back(w2 + 6);
        idle(7);
        wr(3'd0, 16'h0002, w);
        drained("R8");

        // R9 limit write during a running period
        cur_req = "R9";
        wr(3'd4, 16'd10, w);
        wr(3'd0, 16'h0014, w);
        expq.push_back(w + 10);
        idle(2);
        wr(3'd4, 16'd3, w2);
        idle(20);
        drained("R9");
        rd_check(3'd4, 16'd3, "R9");
        wr(3'd0, 16'h0014, w);
        expq.push_back(w + 3);
        idle(15);
        drained("R9");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule